// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

A register-mapped timer with a parameterised number of channels (eight by default). Each channel owns a control/status word, an up-counter and a compare word. Counting advances on a prescaled version of a slow tick, a one-cycle enable pulse supplied from outside within the single bus clock domain. When the count equals the compare value, the next prescaled tick returns the counter to zero, so one period spans compare+1 ticks. That event raises a match flag, which can drive an interrupt line or a DMA request line per channel. Wrapping from the all-ones value raises a separate overflow flag.

A single shared run register holds one start bit per channel. A separate gate register holds one clock-gate bit per channel, and a channel counts only while both of its bits are set. Software loads the counter through the bus, but a load reaches the counter only on the second slow tick after the write. A channel in single-shot mode clears its own start bit on its match event.

Top module: `mct_timer`

## Requirements
- R1: After reset every control word, every counter and both the run register and the gate register read 0. Every compare word reads all ones. A read of an address that decodes to no register returns 0.
- R2: The run register is at byte address 0x000 and the gate register at 0x1000. Channel i has its control word at 0x10+i*0x10, its counter at +4 and its compare word at +8. Block indices beyond the channel count, and word 3 of a block, are unimplemented.
- R3: A running channel increments once per prescaled tick. On a tick where the count equals the compare value, it loads 0 instead and sets the match flag in control bit 15.
- R4: On a tick that advances the counter from all ones to 0 without a compare match, control bit 14 (overflow flag) is set. When the compare value is all ones, that tick sets both flags.
- R5: Writing 0 to control bit 15 or bit 14 clears that flag. Writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R6: Control bits 2:0 choose the prescaler: 4 gives slow/8, 5 gives slow/32, 6 gives slow/128 and 7 gives every slow tick. Codes 0 to 3 stop counting. The prescaler phase restarts whenever the channel is not running or its code is 0 to 3.
- R7: Bit i of the run register starts channel i. While a channel's start bit is clear, its counter holds its value.
- R8: Bit i of the gate register must be set for channel i to count. While it is clear, the counter holds even if the start bit is set.
- R9: A write to a counter becomes visible on readback only at the second slow tick after the write, and it replaces any count on that tick. A second write before then restarts the wait with the new value.
- R10: Control bits 5:4 select the request: 00 none, 01 DMA, 10 interrupt. The interrupt output is the match flag AND control bit 7 AND selection 10. The DMA output is the match flag AND selection 01.
- R11: With control bit 8 set, the channel repeats. With it clear, the match event also clears the channel's start bit, so the counter then rests at 0.
- R12: Read data and a read-valid strobe appear one clock after a read request. Writes take effect at the clock edge of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable pulse of the slow count clock |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one clock after a read request |
| rd_data | output | 32 | Read data |
| irq | output | NUM_CH | Per-channel interrupt request |
| dma | output | NUM_CH | Per-channel DMA request |

## Verification
Read data is due one clock after the request. The driver queues the expected word when it issues the read, and the monitor pops it at the first falling edge on which read-valid is high. Counter, flag and run-bit changes happen at the clock edge that carries a slow-tick pulse, and an interrupt or DMA line follows its flag combinationally. The bench therefore issues slow ticks as isolated pulses four clocks apart and never overlaps them with bus accesses. It reads state and samples the request lines only after a tick sequence has completed, which makes each expected value an exact count of ticks. The deferred counter load is checked by reading after zero, one and two ticks.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int DW    = 32;
  localparam int PSC_W = 7;

  localparam logic [15:0] RUN_OFS  = 16'h0000;
  localparam logic [15:0] GATE_OFS = 16'h1000;

  localparam int B_MFLAG = 15;
  localparam int B_OFLAG = 14;
  localparam int B_MODE  = 8;
  localparam int B_IE    = 7;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_DMA  = 2'b01,
    REQ_IRQ  = 2'b10,
    REQ_RSVD = 2'b11
  } req_sel_e;

  typedef enum logic [2:0] {
    RK_NONE, RK_RUN, RK_GATE, RK_CTRL, RK_CNT, RK_CMP
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] ch;
  } reg_sel_t;

  // codes with bit 2 set run the prescaler
  function automatic logic psc_active(input logic [2:0] code);
    return code[2];
  endfunction

  // terminal value of the prescale phase counter (divide ratio - 1)
  function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] code);
    case (code)
      3'd4:    return PSC_W'(7);
      3'd5:    return PSC_W'(31);
      3'd6:    return PSC_W'(127);
      default: return '0;
    endcase
  endfunction

  function automatic reg_sel_t reg_decode(input logic [15:0] a, input int num_ch);
    reg_sel_t s;
    int blk;
    s.kind = RK_NONE;
    s.ch   = '0;
    blk    = int'(a[11:4]);
    if (a == RUN_OFS) begin
      s.kind = RK_RUN;
    end else if (a == GATE_OFS) begin
      s.kind = RK_GATE;
    end else if (a[15:12] == 4'd0 && a[1:0] == 2'd0 && blk >= 1 && blk <= num_ch) begin
      s.ch = 8'(blk - 1);
      case (a[3:2])
        2'd0:    s.kind = RK_CTRL;
        2'd1:    s.kind = RK_CNT;
        2'd2:    s.kind = RK_CMP;
        default: s.kind = RK_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler
  import mct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       run,
  input  logic [2:0] code,
  output logic       cnt_tick
);
  logic [PSC_W-1:0] phase_q;
  logic [PSC_W-1:0] limit;
  logic             active;

  assign limit    = psc_limit(code);
  assign active   = run && psc_active(code);
  assign cnt_tick = active && slow_tick && (phase_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!active) begin
      phase_q <= '0;
    end else if (slow_tick) begin
      phase_q <= (phase_q == limit) ? '0 : phase_q + PSC_W'(1);
    end
  end
endmodule

// File: rtl/mct_channel.sv
module mct_channel
  import mct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             run,
  input  logic             wr_ctrl,
  input  logic             wr_cnt,
  input  logic             wr_cmp,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    ctrl_rd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq,
  output logic             dma,
  output logic             tick_evt,
  output logic             match_evt,
  output logic             wrap_evt,
  output logic             load_evt,
  output logic             oneshot_evt,
  output logic             mflag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] m);
    return (c == m) ? '0 : c + ONE;
  endfunction

  logic             oflag;
  logic             mode_rep;
  logic             ie;
  req_sel_e         req;
  logic [2:0]       cks;
  logic [CNT_W-1:0] pend_val;
  logic [1:0]       pend_cnt;
  logic             step;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[13:9], wdata[6], wdata[3]};

  mct_prescaler u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .run      (run),
    .code     (cks),
    .cnt_tick (tick_evt)
  );

  assign load_evt    = slow_tick && (pend_cnt == 2'd1) && !wr_cnt;
  assign step        = tick_evt && !load_evt;
  assign match_evt   = step && (cnt_q == cmp_q);
  assign wrap_evt    = step && (cnt_q == '1);
  assign oneshot_evt = match_evt && !mode_rep;

  assign irq = mflag && ie && (req == REQ_IRQ);
  assign dma = mflag && (req == REQ_DMA);

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[B_MFLAG] = mflag;
    ctrl_rd[B_OFLAG] = oflag;
    ctrl_rd[B_MODE]  = mode_rep;
    ctrl_rd[B_IE]    = ie;
    ctrl_rd[5:4]     = req;
    ctrl_rd[2:0]     = cks;
  end

  // control fields and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mflag    <= 1'b0;
      oflag    <= 1'b0;
      mode_rep <= 1'b0;
      ie       <= 1'b0;
      req      <= REQ_NONE;
      cks      <= 3'd0;
    end else begin
      if (wr_ctrl) begin
        mode_rep <= wdata[B_MODE];
        ie       <= wdata[B_IE];
        req      <= req_sel_e'(wdata[5:4]);
        cks      <= wdata[2:0];
      end
      if (match_evt)
        mflag <= 1'b1;
      else if (wr_ctrl && !wdata[B_MFLAG])
        mflag <= 1'b0;
      if (wrap_evt)
        oflag <= 1'b1;
      else if (wr_ctrl && !wdata[B_OFLAG])
        oflag <= 1'b0;
    end
  end

  // deferred counter load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_val <= '0;
      pend_cnt <= 2'd0;
    end else if (wr_cnt) begin
      pend_val <= wdata[CNT_W-1:0];
      pend_cnt <= 2'd2;
    end else if (slow_tick && pend_cnt != 2'd0) begin
      pend_cnt <= pend_cnt - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '1;
    end else begin
      if (wr_cmp)
        cmp_q <= wdata[CNT_W-1:0];
      if (load_evt)
        cnt_q <= pend_val;
      else if (step)
        cnt_q <= advance(cnt_q, cmp_q);
    end
  end
endmodule

// File: rtl/mct_regbus.sv
module mct_regbus
  import mct_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [NUM_CH-1:0]       run_bits,
  input  logic [NUM_CH-1:0]       gate_bits,
  input  logic [NUM_CH*DW-1:0]    ctrl_flat,
  input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
  input  logic [NUM_CH*CNT_W-1:0] cmp_flat,
  output logic                    wr_run,
  output logic                    wr_gate,
  output logic [NUM_CH-1:0]       wr_ctrl,
  output logic [NUM_CH-1:0]       wr_cnt,
  output logic [NUM_CH-1:0]       wr_cmp,
  output logic                    rd_valid,
  output logic [DW-1:0]           rd_data
);
  logic [15:0]   addr16;
  reg_sel_t      sel;
  logic          wr;
  logic [DW-1:0] rd_mux;
  int            idx;

  always_comb begin
    addr16             = '0;
    addr16[ADDR_W-1:0] = bus_addr;
  end

  assign sel = reg_decode(addr16, NUM_CH);
  assign idx = int'(sel.ch);
  assign wr  = bus_req && bus_we;

  assign wr_run  = wr && (sel.kind == RK_RUN);
  assign wr_gate = wr && (sel.kind == RK_GATE);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
      assign wr_ctrl[g] = wr && (sel.kind == RK_CTRL) && (idx == g);
      assign wr_cnt[g]  = wr && (sel.kind == RK_CNT)  && (idx == g);
      assign wr_cmp[g]  = wr && (sel.kind == RK_CMP)  && (idx == g);
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (sel.kind)
      RK_RUN:  rd_mux[NUM_CH-1:0] = run_bits;
      RK_GATE: rd_mux[NUM_CH-1:0] = gate_bits;
      RK_CTRL: rd_mux             = ctrl_flat[idx*DW +: DW];
      RK_CNT:  rd_mux[CNT_W-1:0]  = cnt_flat[idx*CNT_W +: CNT_W];
      RK_CMP:  rd_mux[CNT_W-1:0]  = cmp_flat[idx*CNT_W +: CNT_W];
      default: rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_req && !bus_we;
      rd_data  <= (bus_req && !bus_we) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] dma
);
  logic [NUM_CH-1:0]       start_q;
  logic [NUM_CH-1:0]       gate_q;
  logic [NUM_CH-1:0]       run_vec;
  logic                    wr_run;
  logic                    wr_gate;
  logic [NUM_CH-1:0]       wr_ctrl;
  logic [NUM_CH-1:0]       wr_cnt;
  logic [NUM_CH-1:0]       wr_cmp;
  logic [NUM_CH*DW-1:0]    ctrl_flat;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [NUM_CH*CNT_W-1:0] cmp_flat;
  logic [NUM_CH-1:0]       tick_vec;
  logic [NUM_CH-1:0]       match_vec;
  logic [NUM_CH-1:0]       wrap_vec;
  logic [NUM_CH-1:0]       load_vec;
  logic [NUM_CH-1:0]       oneshot_vec;
  logic [NUM_CH-1:0]       mflag_vec;

  assign run_vec = start_q & gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      gate_q  <= '0;
    end else begin
      if (wr_run)
        start_q <= bus_wdata[NUM_CH-1:0];
      else
        start_q <= start_q & ~oneshot_vec;
      if (wr_gate)
        gate_q <= bus_wdata[NUM_CH-1:0];
    end
  end

  mct_regbus #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .run_bits (start_q),
    .gate_bits(gate_q),
    .ctrl_flat(ctrl_flat),
    .cnt_flat (cnt_flat),
    .cmp_flat (cmp_flat),
    .wr_run   (wr_run),
    .wr_gate  (wr_gate),
    .wr_ctrl  (wr_ctrl),
    .wr_cnt   (wr_cnt),
    .wr_cmp   (wr_cmp),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      mct_channel #(.CNT_W(CNT_W)) u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_tick  (slow_tick),
        .run        (run_vec[g]),
        .wr_ctrl    (wr_ctrl[g]),
        .wr_cnt     (wr_cnt[g]),
        .wr_cmp     (wr_cmp[g]),
        .wdata      (bus_wdata),
        .ctrl_rd    (ctrl_flat[g*DW +: DW]),
        .cnt_q      (cnt_flat[g*CNT_W +: CNT_W]),
        .cmp_q      (cmp_flat[g*CNT_W +: CNT_W]),
        .irq        (irq[g]),
        .dma        (dma[g]),
        .tick_evt   (tick_vec[g]),
        .match_evt  (match_vec[g]),
        .wrap_evt   (wrap_vec[g]),
        .load_evt   (load_vec[g]),
        .oneshot_evt(oneshot_vec[g]),
        .mflag      (mflag_vec[g])
      );
    end
  endgenerate
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_req,
  input logic                    bus_we,
  input logic                    rd_valid,
  input logic [NUM_CH-1:0]       irq,
  input logic [NUM_CH-1:0]       dma,
  input logic [NUM_CH-1:0]       start_q,
  input logic [NUM_CH-1:0]       tick_vec,
  input logic [NUM_CH-1:0]       load_vec,
  input logic [NUM_CH-1:0]       match_vec,
  input logic [NUM_CH-1:0]       oneshot_vec,
  input logic [NUM_CH-1:0]       mflag_vec,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
  p_rdlat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> rd_valid);

  p_rdsrc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_req && !bus_we));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_vec[g] |=> (cnt_flat[g*CNT_W +: CNT_W] == '0));

      p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_vec[g] |=> mflag_vec[g]);

      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_vec[g] && !load_vec[g]) |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));

      p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq[g] && dma[g]));

      p_req_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[g] || dma[g]) |-> mflag_vec[g]);

      p_oneshot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_vec[g] && !(bus_req && bus_we)) |=> !start_q[g]);
    end
  endgenerate
endmodule

bind mct_timer mct_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .rd_valid   (rd_valid),
  .irq        (irq),
  .dma        (dma),
  .start_q    (start_q),
  .tick_vec   (tick_vec),
  .load_vec   (load_vec),
  .match_vec  (match_vec),
  .oneshot_vec(oneshot_vec),
  .mflag_vec  (mflag_vec),
  .cnt_flat   (cnt_flat)
);

// File: tb/mct_timer_bench.sv
`timescale 1ns/1ps
module mct_timer_bench;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              slow_tick = 1'b0;
  logic              bus_req = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic [NUM_CH-1:0] irq;
  logic [NUM_CH-1:0] dma;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mct_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_mct_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .irq      (irq),
    .dma      (dma)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected word per returned read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R12 unrequested read data: got %h expected none", rd_data);
      end else begin
        check(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    check({31'b0, rd_valid}, 32'd1, "R12 read valid one clock after request");
  endtask

  task automatic slow(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 reset state and decode
    rd(13'h010, 32'h0, "R1 ctrl0 reset");
    rd(13'h014, 32'h0, "R1 cnt0 reset");
    rd(13'h018, 32'hFFFF_FFFF, "R1 cmp0 reset");
    rd(13'h000, 32'h0, "R1 run reg reset");
    rd(13'h1000, 32'h0, "R1 gate reg reset");
    rd(13'h088, 32'hFFFF_FFFF, "R2 cmp7 reset");
    rd(13'h098, 32'h0, "R2 block past last channel reads 0");
    rd(13'h01C, 32'h0, "R2 word3 reads 0");
    rd(13'h004, 32'h0, "R1 unimplemented reads 0");
    check({24'b0, irq}, 32'h0, "R1 irq after reset");
    check({24'b0, dma}, 32'h0, "R1 dma after reset");

    // R9 deferred counter write (channel idle)
    wr(13'h014, 32'd100);
    rd(13'h014, 32'd0, "R9 no effect before any slow tick");
    slow(1);
    rd(13'h014, 32'd0, "R9 no effect after one slow tick");
    slow(1);
    rd(13'h014, 32'd100, "R9 loaded after two slow ticks");

    // R8 gate clear blocks counting, R7 start clear blocks counting
    wr(13'h010, 32'h107);
    wr(13'h000, 32'h1);
    slow(3);
    rd(13'h014, 32'd100, "R8 gate clear holds counter");
    wr(13'h000, 32'h0);
    wr(13'h1000, 32'h1);
    slow(2);
    rd(13'h014, 32'd100, "R7 start clear holds counter");

    // R3 periodic count and restart
    wr(13'h014, 32'd0);
    slow(2);
    wr(13'h018, 32'd3);
    wr(13'h000, 32'h1);
    slow(3);
    rd(13'h014, 32'd3, "R3 counted to compare");
    rd(13'h010, 32'h107, "R3 no flag before restart tick");
    slow(1);
    rd(13'h014, 32'd0, "R3 restart to zero");
    rd(13'h010, 32'h8107, "R3 match flag set");
    slow(2);
    rd(13'h014, 32'd2, "R11 repeat mode keeps counting");
    wr(13'h000, 32'h0);

    // R5 flag write semantics
    wr(13'h010, 32'h8107);
    rd(13'h010, 32'h8107, "R5 writing 1 keeps match flag");
    wr(13'h010, 32'h0107);
    rd(13'h010, 32'h0107, "R5 writing 0 clears match flag");

    // R10 request routing
    wr(13'h010, 32'h01A7);
    wr(13'h000, 32'h1);
    slow(2);
    check({31'b0, irq[0]}, 32'd1, "R10 irq with flag, enable, select 10");
    check({31'b0, dma[0]}, 32'd0, "R10 no dma with select 10");
    wr(13'h010, 32'h8127);
    check({31'b0, irq[0]}, 32'd0, "R10 irq off with enable clear");
    wr(13'h010, 32'h8117);
    check({31'b0, dma[0]}, 32'd1, "R10 dma with select 01");
    check({31'b0, irq[0]}, 32'd0, "R10 no irq with select 01");
    rd(13'h010, 32'h8117, "R10 ctrl readback");
    wr(13'h010, 32'h0117);
    check({31'b0, dma[0]}, 32'd0, "R10 dma drops with flag");
    wr(13'h000, 32'h0);

    // R6 prescaler ratios (counter now 0)
    wr(13'h018, 32'hFFFF_FFFF);
    wr(13'h010, 32'h104);
    wr(13'h000, 32'h1);
    slow(15);
    rd(13'h014, 32'd1, "R6 div8 after 15 ticks");
    slow(1);
    rd(13'h014, 32'd2, "R6 div8 after 16 ticks");
    wr(13'h010, 32'h105);
    slow(64);
    rd(13'h014, 32'd4, "R6 div32 after 64 ticks");
    wr(13'h010, 32'h106);
    slow(128);
    rd(13'h014, 32'd5, "R6 div128 after 128 ticks");
    wr(13'h010, 32'h100);
    slow(5);
    rd(13'h014, 32'd5, "R6 code 0 stops counting");
    wr(13'h010, 32'h107);
    slow(3);
    rd(13'h014, 32'd8, "R6 undivided after 3 ticks");
    wr(13'h000, 32'h0);

    // R4 overflow on channel 1
    wr(13'h028, 32'd5);
    wr(13'h024, 32'hFFFF_FFFF);
    slow(2);
    wr(13'h020, 32'h107);
    wr(13'h1000, 32'hFF);
    wr(13'h000, 32'h2);
    slow(1);
    rd(13'h024, 32'd0, "R4 wrap to zero");
    rd(13'h020, 32'h4107, "R4 overflow flag without match");
    wr(13'h020, 32'h0107);
    rd(13'h020, 32'h0107, "R5 writing 0 clears overflow flag");
    wr(13'h000, 32'h0);
    wr(13'h028, 32'hFFFF_FFFF);
    wr(13'h024, 32'hFFFF_FFFE);
    slow(2);
    wr(13'h000, 32'h2);
    slow(1);
    rd(13'h020, 32'h0107, "R4 no flag before wrap");
    slow(1);
    rd(13'h020, 32'hC107, "R4 compare all ones sets both flags");
    wr(13'h000, 32'h0);

    // R11 single-shot on channel 7
    wr(13'h088, 32'd2);
    wr(13'h080, 32'h007);
    wr(13'h000, 32'h80);
    slow(2);
    rd(13'h084, 32'd2, "R11 oneshot counting");
    rd(13'h000, 32'h80, "R11 start bit still set");
    slow(1);
    rd(13'h084, 32'd0, "R11 oneshot match to zero");
    rd(13'h000, 32'h00, "R11 start bit cleared by match");
    rd(13'h080, 32'h8007, "R11 oneshot flag");
    slow(3);
    rd(13'h084, 32'd0, "R11 counter rests after oneshot");
    rd(13'h014, 32'd8, "R2 channel 0 untouched by channel 7");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 missing read data: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule